// File: doc/BRIEF.md
# Core power state controller

This block follows the activity of the hardware threads of a processor core and derives from it a single power state. The state drives the clock gating cells, the power switches and the retention logic elsewhere in the chip. When the last running thread goes to sleep, the core is clock gated straight away. A down-counter then runs for a programmable number of cycles, and if nothing wakes the core before it expires, the core drops to full power gating.

Control inputs handle the situations around that basic flow. A switch-out request parks the core powered off and ignores its threads until a take-over request hands it a new state. A drain request freezes any pending countdown so that the core can be quiesced. A resume that follows a drain re-arms the countdown from the full latency, but only if the core is still clock gated with every thread idle.

Top module: `core_pwr_ctrl`

## Requirements
- R1: The state is coded as undefined = 0, on = 1, clock gated = 2 and off = 3. The state reads 0 while rst_ni is low. In the first cycle after reset it becomes 3 if start_off_i is high, and 1 otherwise.
- R2: A suspend pulse that leaves no thread active sets the state to 2 and raises gate_pend_o. A suspend pulse while another thread stays active leaves the state at 1.
- R3: Once the state has entered 2 with a latency L, it becomes 3 exactly L cycles later if nothing intervenes. gate_lat_i is captured when the countdown starts, so later changes have no effect on that countdown.
- R4: A latency input of 0 selects the default latency of 300 cycles.
- R5: An activate pulse on any thread sets the state to 1 and clears gate_pend_o. It wins over a countdown that expires in the same cycle.
- R6: A switch-out request sets the state to 3 and clears gate_pend_o. Thread pulses are then ignored until a take-over.
- R7: A drain request clears gate_pend_o and leaves the state unchanged. The countdown it cancels never leads to state 3.
- R8: A resume that follows a drain restarts the countdown from the full latency, but only when the state is 2 and no thread is active. A resume in any other state has no effect, and so does a resume without a preceding drain.
- R9: A take-over request loads takeover_state_i into the state, clears gate_pend_o and ends the switched-out condition, so thread pulses take effect again. Take-over has priority over switch-out, and switch-out has priority over thread pulses.
- R10: gate_pend_o is high only while the state is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_off_i | input | 1 | Core begins switched out after reset |
| act_i | input | N_THR | Per-thread activate pulses |
| susp_i | input | N_THR | Per-thread suspend pulses |
| swout_i | input | 1 | Switch-out request |
| takeover_i | input | 1 | Take-over request |
| takeover_state_i | input | 2 | State loaded by take-over |
| drain_i | input | 1 | Drain request |
| resume_i | input | 1 | Resume after drain |
| gate_lat_i | input | LAT_W | Power gating latency in cycles, 0 selects the default |
| pwr_state_o | output | 2 | Encoded power state |
| gate_pend_o | output | 1 | Power gating countdown running |

## Verification
The hardest case to reach is a countdown that expires in the very cycle a thread wakes. The stimulus reaches it by programming a short latency and counting edges from the suspend, so that the activate pulse lands on the expiry edge. The default latency of 300 is covered by waiting for exactly 299 edges and then one more. The resume case requires a drain first, and the stimulus brings both the idle-gated state and the running state to that point.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    PS_UNDEF = 2'd0,
    PS_ON    = 2'd1,
    PS_CGATE = 2'd2,
    PS_OFF   = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/cpc_thread_track.sv
module cpc_thread_track #(
  parameter int N_THR = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_THR-1:0] act_i,
  input  logic [N_THR-1:0] susp_i,
  input  logic             clear_i,
  input  logic             hold_i,
  output logic             act_any_o,
  output logic             last_susp_o,
  output logic             idle_o
);
  logic [N_THR-1:0] active_q;
  logic [N_THR-1:0] active_nx;

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    // activate wins over suspend of the same thread
    assign active_nx[t] = (active_q[t] & ~susp_i[t]) | act_i[t];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       active_q[t] <= 1'b0;
      else if (clear_i)  active_q[t] <= 1'b0;
      else if (!hold_i)  active_q[t] <= active_nx[t];
    end
  end

  assign act_any_o   = !hold_i && (|act_i);
  assign last_susp_o = !hold_i && !clear_i && (|(active_q & susp_i)) && (active_nx == '0);
  assign idle_o      = (active_q == '0);
endmodule

// File: rtl/cpc_gate_timer.sv
module cpc_gate_timer #(
  parameter int LAT_W   = 16,
  parameter int DEF_LAT = 300
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cancel_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             pend_o,
  output logic             expire_o
);
  localparam logic [LAT_W-1:0] LAT_DEF = LAT_W'(DEF_LAT);
  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

  logic [LAT_W-1:0] cnt_q;
  logic             pend_q;
  logic [LAT_W-1:0] lat_eff;

  assign lat_eff  = (lat_i == '0) ? LAT_DEF : lat_i;
  assign expire_o = pend_q && (cnt_q == LAT_ONE) && !cancel_i;
  assign pend_o   = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (cancel_i) begin
      pend_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= lat_eff;
      pend_q <= 1'b1;
    end else if (pend_q) begin
      if (cnt_q == LAT_ONE) pend_q <= 1'b0;
      else                  cnt_q  <= cnt_q - LAT_ONE;
    end
  end
endmodule

// File: rtl/cpc_state_fsm.sv
module cpc_state_fsm
  import cpc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_off_i,
  input  logic       takeover_i,
  input  logic [1:0] takeover_state_i,
  input  logic       swout_i,
  input  logic       drain_i,
  input  logic       resume_i,
  input  logic       act_any_i,
  input  logic       last_susp_i,
  input  logic       idle_i,
  input  logic       expire_i,
  output pwr_state_e state_o,
  output logic       hold_o,
  output logic       clear_o,
  output logic       init_o,
  output logic       start_o,
  output logic       cancel_o
);
  pwr_state_e state_q, state_d;
  logic       sw_q, sw_d;
  logic       init_q;
  logic       drained_q, drained_d;

  always_comb begin
    state_d   = state_q;
    sw_d      = sw_q;
    drained_d = drained_q;
    start_o   = 1'b0;
    cancel_o  = 1'b0;
    clear_o   = 1'b0;
    if (init_q) begin
      state_d = start_off_i ? PS_OFF : PS_ON;
      sw_d    = start_off_i;
    end else if (takeover_i) begin
      state_d   = pwr_state_e'(takeover_state_i);
      sw_d      = 1'b0;
      cancel_o  = 1'b1;
      drained_d = 1'b0;
    end else if (swout_i) begin
      state_d   = PS_OFF;
      sw_d      = 1'b1;
      cancel_o  = 1'b1;
      clear_o   = 1'b1;
      drained_d = 1'b0;
    end else begin
      if (drain_i) begin
        cancel_o  = 1'b1;
        drained_d = 1'b1;
      end
      if (act_any_i) begin
        state_d  = PS_ON;
        cancel_o = 1'b1;
      end else if (last_susp_i) begin
        state_d = PS_CGATE;
        start_o = !drain_i;
      end else if (expire_i && state_q == PS_CGATE) begin
        state_d = PS_OFF;
      end else if (resume_i && drained_q && !drain_i) begin
        drained_d = 1'b0;
        start_o   = (state_q == PS_CGATE) && idle_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PS_UNDEF;
      sw_q      <= 1'b0;
      init_q    <= 1'b1;
      drained_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      sw_q      <= sw_d;
      init_q    <= 1'b0;
      drained_q <= drained_d;
    end
  end

  assign state_o = state_q;
  assign hold_o  = sw_q || init_q;
  assign init_o  = init_q;
endmodule

// File: rtl/core_pwr_ctrl.sv
module core_pwr_ctrl
  import cpc_pkg::*;
#(
  parameter int N_THR   = 4,
  parameter int LAT_W   = 16,
  parameter int DEF_LAT = 300
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_off_i,
  input  logic [N_THR-1:0] act_i,
  input  logic [N_THR-1:0] susp_i,
  input  logic             swout_i,
  input  logic             takeover_i,
  input  logic [1:0]       takeover_state_i,
  input  logic             drain_i,
  input  logic             resume_i,
  input  logic [LAT_W-1:0] gate_lat_i,
  output logic [1:0]       pwr_state_o,
  output logic             gate_pend_o
);
  logic       act_any, last_susp, idle, expire;
  logic       hold, clear, init, start, cancel;
  pwr_state_e state;

  cpc_thread_track #(.N_THR(N_THR)) u_track (
    .clk_i, .rst_ni, .act_i, .susp_i,
    .clear_i(clear), .hold_i(hold),
    .act_any_o(act_any), .last_susp_o(last_susp), .idle_o(idle)
  );

  cpc_gate_timer #(.LAT_W(LAT_W), .DEF_LAT(DEF_LAT)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .cancel_i(cancel), .lat_i(gate_lat_i),
    .pend_o(gate_pend_o), .expire_o(expire)
  );

  cpc_state_fsm u_fsm (
    .clk_i, .rst_ni, .start_off_i, .takeover_i, .takeover_state_i,
    .swout_i, .drain_i, .resume_i,
    .act_any_i(act_any), .last_susp_i(last_susp), .idle_i(idle), .expire_i(expire),
    .state_o(state), .hold_o(hold), .clear_o(clear), .init_o(init),
    .start_o(start), .cancel_o(cancel)
  );

  assign pwr_state_o = state;
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter int N_THR = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_THR-1:0] act_i,
  input logic [N_THR-1:0] susp_i,
  input logic             swout_i,
  input logic             takeover_i,
  input logic [1:0]       takeover_state_i,
  input logic             drain_i,
  input logic [1:0]       pwr_state_o,
  input logic             gate_pend_o,
  input logic             hold,
  input logic             init
);
  // R1
  no_undef_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init && pwr_state_o != 2'd0 && !takeover_i) |=> pwr_state_o != 2'd0);
  // R5
  act_wakes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold && !takeover_i && !swout_i && (|act_i)) |=> (pwr_state_o == 2'd1 && !gate_pend_o));
  // R6
  swout_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init && !takeover_i && swout_i) |=> (pwr_state_o == 2'd3 && !gate_pend_o));
  // R7
  drain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init && !takeover_i && !swout_i && drain_i && act_i == '0 && susp_i == '0)
      |=> (pwr_state_o == $past(pwr_state_o) && !gate_pend_o));
  // R9
  takeover_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init && takeover_i) |=> (pwr_state_o == $past(takeover_state_i) && !gate_pend_o));
  // R10
  pend_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_pend_o |-> pwr_state_o == 2'd2);
endmodule

bind core_pwr_ctrl cpc_checker #(.N_THR(N_THR)) u_chk (
  .clk_i, .rst_ni, .act_i, .susp_i, .swout_i, .takeover_i, .takeover_state_i,
  .drain_i, .pwr_state_o, .gate_pend_o, .hold(hold), .init(init)
);

// File: tb/core_pwr_ctrl_test.sv
`timescale 1ns/1ps
module core_pwr_ctrl_test;
  localparam int NT = 4;
  localparam logic [1:0] S_UND = 2'd0, S_ON = 2'd1, S_CG = 2'd2, S_OFF = 2'd3;

  typedef struct {
    logic [1:0] st;
    logic       pd;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_off = 1'b0;
  logic [NT-1:0] act = '0, susp = '0;
  logic swout = 1'b0, takeover = 1'b0, drain = 1'b0, resume = 1'b0;
  logic [1:0] tk_state = 2'd0;
  logic [15:0] lat = 16'd5;
  logic [1:0] pwr_state;
  logic gate_pend;

  int checks = 0, fails = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  core_pwr_ctrl #(.N_THR(NT), .LAT_W(16), .DEF_LAT(300)) uut (
    .clk_i(clk), .rst_ni, .start_off_i(start_off), .act_i(act), .susp_i(susp),
    .swout_i(swout), .takeover_i(takeover), .takeover_state_i(tk_state),
    .drain_i(drain), .resume_i(resume), .gate_lat_i(lat),
    .pwr_state_o(pwr_state), .gate_pend_o(gate_pend)
  );

  // monitor: compares results after each posedge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pwr_state !== e.st || gate_pend !== e.pd) begin
        fails++;
        $display("FAIL %s: state=%0d pend=%0b expected state=%0d pend=%0b",
                 e.tag, pwr_state, gate_pend, e.st, e.pd);
      end
    end
  end

  task automatic cyc(input logic [1:0] st, input logic pd, input string tag);
    exp_t e;
    @(posedge clk);
    e.st = st; e.pd = pd; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    act = '0; susp = '0; swout = 1'b0; takeover = 1'b0; drain = 1'b0; resume = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic direct(input logic [1:0] st, input string tag);
    checks++;
    if (pwr_state !== st) begin
      fails++;
      $display("FAIL %s: state=%0d expected state=%0d", tag, pwr_state, st);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    run(3);
    direct(S_UND, "R1 in reset");
    rst_ni = 1'b1;
    cyc(S_ON, 1'b0, "R1 leaves reset on");

    act = 4'b0011;            cyc(S_ON, 1'b0, "R5 two threads on");
    susp = 4'b0001;           cyc(S_ON, 1'b0, "R2 one still active");
    susp = 4'b0010;           cyc(S_CG, 1'b1, "R2 last suspend gates");
    run(3);                   cyc(S_CG, 1'b1, "R3 gated before L");
                              cyc(S_OFF, 1'b0, "R3 off after L");

    act = 4'b0100;            cyc(S_ON, 1'b0, "R5 wake from off");
    susp = 4'b0100;           cyc(S_CG, 1'b1, "R2 gate again");
    run(2);
    act = 4'b1000;            cyc(S_ON, 1'b0, "R5 cancel countdown");
    run(5);                   cyc(S_ON, 1'b0, "R5 stays on");

    susp = 4'b1000;           cyc(S_CG, 1'b1, "R3 start at L=5");
    lat = 16'd20;
    run(3);                   cyc(S_CG, 1'b1, "R3 latched latency");
                              cyc(S_OFF, 1'b0, "R3 latched latency off");

    lat = 16'd0;
    act = 4'b0001;            cyc(S_ON, 1'b0, "R5 wake");
    susp = 4'b0001;           cyc(S_CG, 1'b1, "R4 default start");
    run(298);                 cyc(S_CG, 1'b1, "R4 gated at 299");
                              cyc(S_OFF, 1'b0, "R4 off at 300");

    lat = 16'd5;
    act = 4'b0001;            cyc(S_ON, 1'b0, "R5 wake");
    susp = 4'b0001;           cyc(S_CG, 1'b1, "R2 gate");
    run(3);                   cyc(S_CG, 1'b1, "R3 one left");
    act = 4'b0010;            cyc(S_ON, 1'b0, "R5 activation beats expiry");

    susp = 4'b0010;           cyc(S_CG, 1'b1, "R2 gate");
    drain = 1'b1;             cyc(S_CG, 1'b0, "R7 drain cancels");
    run(9);                   cyc(S_CG, 1'b0, "R7 no power down");
    resume = 1'b1;            cyc(S_CG, 1'b1, "R8 resume restarts");
    run(3);                   cyc(S_CG, 1'b1, "R8 full latency");
                              cyc(S_OFF, 1'b0, "R8 off after resume");

    act = 4'b0001;            cyc(S_ON, 1'b0, "R5 wake");
    drain = 1'b1;             cyc(S_ON, 1'b0, "R7 drain while on");
    resume = 1'b1;            cyc(S_ON, 1'b0, "R8 resume while on");

    susp = 4'b0001;           cyc(S_CG, 1'b1, "R2 gate");
    swout = 1'b1;             cyc(S_OFF, 1'b0, "R6 switch out");
    act = 4'b0010;            cyc(S_OFF, 1'b0, "R6 activity ignored");
    run(8);                   cyc(S_OFF, 1'b0, "R6 stays off");
    takeover = 1'b1; tk_state = S_ON;
                              cyc(S_ON, 1'b0, "R9 takeover on");
    act = 4'b0100;            cyc(S_ON, 1'b0, "R9 activity honoured");
    susp = 4'b0100;           cyc(S_CG, 1'b1, "R9 last suspend gates");
    takeover = 1'b1; tk_state = S_CG;
                              cyc(S_CG, 1'b0, "R9 takeover cancels");
    resume = 1'b1;            cyc(S_CG, 1'b0, "R8 resume without drain");
    drain = 1'b1;             cyc(S_CG, 1'b0, "R7 drain idle");
    resume = 1'b1;            cyc(S_CG, 1'b1, "R8 resume idle gated");
    takeover = 1'b1; swout = 1'b1; tk_state = S_ON;
                              cyc(S_ON, 1'b0, "R9 takeover beats switch-out");

    rst_ni = 1'b0; start_off = 1'b1;
    run(2);
    direct(S_UND, "R1 in reset again");
    rst_ni = 1'b1;
    cyc(S_OFF, 1'b0, "R1 starts switched out");
    act = 4'b0001;            cyc(S_OFF, 1'b0, "R6 start-off ignores activity");
    takeover = 1'b1; tk_state = S_ON;
                              cyc(S_ON, 1'b0, "R9 takeover after start-off");

    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule